// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block times the strobes of a multiplexed external memory bus for an 8-bit controller core. The bus machine cycle is twelve input clocks long. At the last clock of each machine cycle the block samples a request from the core. The request is an internal code fetch, an external code fetch, an external data read or an external data write, together with a 16-bit address and a write byte. Over the next twelve clocks the block plays out the address-latch strobe, the code-read strobe, the data read and write strobes, the drive enable and value of the shared low address/data port, and the upper address byte. It also captures the byte read back from the shared port.

A single auxiliary control bit reduces emissions. When the bit is set, the address-latch strobe is held low for every machine cycle that only fetches from internal memory. Any external code or data cycle still produces the strobe, and suppression resumes with the next internal cycle. Whether a cycle is quiet is decided once, when the cycle's request is sampled, so a pulse is never cut short.

Clock positions below count the clocks after the sampling edge: position 0 is the clock that follows the edge at which the request is taken, and position 11 is the last clock of the cycle.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is held and in the clock after it, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `p0_oe` is 0, `rdata` is 0, `rdata_vld` is 0 and `req_take` is 1. The suppression bit resets to 0.
- R2: `req_take` is high in position 11 only, once every 12 clocks. The request on `req_op` (0 internal fetch, 1 external fetch, 2 external read, 3 external write), `req_addr` and `req_wdata` is sampled at the clock edge that ends a `req_take` clock.
- R3: In a fetch cycle (op 0 or 1) that is not quiet, `ale` is high in positions 0-1 and 6-7, so it pulses every 6 clocks for 2 clocks each time.
- R4: In a data cycle (op 2 or 3), `ale` is high in positions 0-1 only; the second pulse is dropped.
- R5: In an external fetch, `psen_n` is low in positions 3-5, one clock after `ale` falls, for 3 clocks. It stays high in all other cycles.
- R6: In an external read, `rd_n` is low in positions 5-10; in an external write, `wr_n` is low in positions 5-10. That is 3 clocks after `ale` falls, for 6 clocks. At most one of `psen_n`, `rd_n` and `wr_n` is low at any time.
- R7: In every external cycle `p0_oe` is 1 in positions 0-1 with `p0_out` equal to `req_addr[7:0]`. In a write, `p0_oe` is also 1 in positions 4-11 with `p0_out` equal to the write byte, which is one clock before `wr_n` falls until one clock after it rises. `p0_oe` is 0 at all other times, including all of a read strobe.
- R8: `p2_out` equals `req_addr[15:8]` throughout an external cycle and is 0 throughout an internal fetch.
- R9: `p0_in` is captured into `rdata` at the edge that ends position 5 of an external fetch and position 10 of an external read, which is the edge just before the strobe rises. `rdata_vld` is 1 for the one following clock, and `rdata` holds its value until the next capture.
- R10: A clock with `cfg_we` high loads `cfg_ale_off` into the suppression bit. While the bit is set, an internal fetch cycle has `ale` low in all 12 positions.
- R11: With the bit set, external cycles still produce the `ale` pulses of R3/R4, and the next internal fetch is quiet again. A cycle is quiet only if the bit was set before the edge that samples its request. A change made in the middle of a cycle takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| req_op | input | 2 | Request type for the next machine cycle |
| req_addr | input | 16 | Address for the next machine cycle |
| req_wdata | input | 8 | Write byte for the next machine cycle |
| req_take | output | 1 | High in the last clock of a machine cycle; request sampled at its end |
| cfg_we | input | 1 | Write strobe for the suppression bit |
| cfg_ale_off | input | 1 | Value written into the suppression bit |
| p0_in | input | 8 | Byte read from the shared address/data port |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | External code-read strobe, active low |
| rd_n | output | 1 | External data-read strobe, active low |
| wr_n | output | 1 | External data-write strobe, active low |
| p0_out | output | 8 | Byte driven on the shared port |
| p0_oe | output | 1 | Drive enable of the shared port |
| p2_out | output | 8 | Upper address byte |
| rdata | output | 8 | Last captured read byte |
| rdata_vld | output | 1 | One-clock pulse after a capture |

## Verification
The bench plays a run of machine cycles that mixes all four request types. The run includes back-to-back data cycles, which show that the dropped pulse belongs to each data cycle and not only to the first. Internal fetches are run with the suppression bit clear, set, and written in the middle of a cycle, which separates a per-cycle decision from one taken at once. External cycles placed between quiet internal fetches show that the strobe returns and then stops again. The shared input port changes on every clock, so a capture taken one edge early or late gives a different byte.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    // Machine cycle timing, in input clocks after the request-sampling edge
    localparam int CYC_CLKS  = 12;
    localparam int ALE_LEN   = 2;
    localparam int ALE_A_POS = 0;
    localparam int ALE_B_POS = CYC_CLKS / 2;
    localparam int PSEN_POS  = ALE_A_POS + ALE_LEN + 1;
    localparam int PSEN_LEN  = 3;
    localparam int DSTB_POS  = ALE_A_POS + ALE_LEN + 3;
    localparam int DSTB_LEN  = 6;
    localparam int WD_LEAD   = 1;
    localparam int WD_TAIL   = 1;

    typedef enum logic [1:0] {
        OP_IFETCH = 2'd0,
        OP_XFETCH = 2'd1,
        OP_XREAD  = 2'd2,
        OP_XWRITE = 2'd3
    } bus_op_e;

endpackage

// File: rtl/bus_phase_ctr.sv
module bus_phase_ctr #(
    parameter int CYC = 12,
    localparam int CW = $clog2(CYC)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] pos,
    output logic          last
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        last  = (cnt_q == CW'(CYC - 1));
        cnt_d = last ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= CW'(CYC - 1);
        else     cnt_q <= cnt_d;
    end

    assign pos = cnt_q;

endmodule

// File: rtl/bus_cycle_ctx.sv
module bus_cycle_ctx
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  bus_op_e           req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_we,
    input  logic              cfg_ale_off,
    output bus_op_e           op,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              quiet
);

    typedef struct packed {
        bus_op_e           op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              quiet;
        logic              ale_off;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        if (start) begin
            ctx_d.op    = req_op;
            ctx_d.addr  = req_addr;
            ctx_d.wdata = req_wdata;
            // decided once per cycle from the bit held before this edge
            ctx_d.quiet = ctx_q.ale_off && (req_op == OP_IFETCH);
        end
        if (cfg_we) ctx_d.ale_off = cfg_ale_off;
    end

    always_ff @(posedge clk) begin
        if (rst) ctx_q <= '0;
        else     ctx_q <= ctx_d;
    end

    assign op    = ctx_q.op;
    assign addr  = ctx_q.addr;
    assign wdata = ctx_q.wdata;
    assign quiet = ctx_q.quiet;

endmodule

// File: rtl/bus_strobe_dec.sv
module bus_strobe_dec
    import bus_seq_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic [CW-1:0] pos,
    input  bus_op_e       op,
    input  logic          quiet,
    output logic          ale,
    output logic          psen_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic          p0_oe,
    output logic          p0_addr_sel,
    output logic          ext,
    output logic          cap_now
);

    function automatic logic in_win(input logic [CW-1:0] p, input int s, input int l);
        return (int'(p) >= s) && (int'(p) < s + l);
    endfunction

    logic is_data, addr_ph, wdat_ph;

    always_comb begin
        ext     = (op != OP_IFETCH);
        is_data = (op == OP_XREAD) || (op == OP_XWRITE);
        ale     = !quiet && (in_win(pos, ALE_A_POS, ALE_LEN) ||
                             (!is_data && in_win(pos, ALE_B_POS, ALE_LEN)));
        psen_n  = !((op == OP_XFETCH) && in_win(pos, PSEN_POS, PSEN_LEN));
        rd_n    = !((op == OP_XREAD)  && in_win(pos, DSTB_POS, DSTB_LEN));
        wr_n    = !((op == OP_XWRITE) && in_win(pos, DSTB_POS, DSTB_LEN));
        addr_ph = ext && in_win(pos, ALE_A_POS, ALE_LEN);
        wdat_ph = (op == OP_XWRITE) &&
                  in_win(pos, DSTB_POS - WD_LEAD, DSTB_LEN + WD_LEAD + WD_TAIL);
        p0_oe       = addr_ph || wdat_ph;
        p0_addr_sel = addr_ph;
        cap_now = ((op == OP_XFETCH) && (int'(pos) == PSEN_POS + PSEN_LEN - 1)) ||
                  ((op == OP_XREAD)  && (int'(pos) == DSTB_POS + DSTB_LEN - 1));
    end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W,
    localparam int CW    = $clog2(CYC_CLKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_take,
    input  logic              cfg_we,
    input  logic              cfg_ale_off,
    input  logic [DATA_W-1:0] p0_in,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] p0_out,
    output logic              p0_oe,
    output logic [HI_W-1:0]   p2_out,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld
);

    logic [CW-1:0]     pos;
    logic              last;
    bus_op_e           cur_op;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic              cur_quiet;
    logic              addr_sel, ext, cap_now;

    bus_phase_ctr #(.CYC(CYC_CLKS)) u_phase (
        .clk (clk),
        .rst (rst),
        .pos (pos),
        .last(last)
    );

    bus_cycle_ctx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctx (
        .clk        (clk),
        .rst        (rst),
        .start      (last),
        .req_op     (bus_op_e'(req_op)),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .cfg_we     (cfg_we),
        .cfg_ale_off(cfg_ale_off),
        .op         (cur_op),
        .addr       (cur_addr),
        .wdata      (cur_wdata),
        .quiet      (cur_quiet)
    );

    bus_strobe_dec #(.CW(CW)) u_dec (
        .pos        (pos),
        .op         (cur_op),
        .quiet      (cur_quiet),
        .ale        (ale),
        .psen_n     (psen_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .p0_oe      (p0_oe),
        .p0_addr_sel(addr_sel),
        .ext        (ext),
        .cap_now    (cap_now)
    );

    // Read-data capture
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              vld;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = 1'b0;
        if (cap_now) begin
            cap_d.data = p0_in;
            cap_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cap_q <= '0;
        else     cap_q <= cap_d;
    end

    assign req_take  = last;
    assign rdata     = cap_q.data;
    assign rdata_vld = cap_q.vld;
    assign p0_out    = addr_sel ? cur_addr[DATA_W-1:0] : cur_wdata;
    assign p2_out    = ext ? cur_addr[ADDR_W-1:DATA_W] : '0;

endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk
    import bus_seq_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic req_take,
    input logic ale,
    input logic psen_n,
    input logic rd_n,
    input logic wr_n,
    input logic p0_oe,
    input logic rdata_vld
);

    logic [3:0] dlow_q;
    logic [4:0] gap_q;
    logic       seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dlow_q <= '0;
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            dlow_q <= (!rd_n || !wr_n) ? dlow_q + 4'd1 : 4'd0;
            gap_q  <= req_take ? 5'd0 : gap_q + 5'd1;
            if (req_take) seen_q <= 1'b1;
        end
    end

    // R2: one request slot every CYC_CLKS clocks
    assert_cycle_len_R2: assert property (@(posedge clk) disable iff (rst)
        (req_take && seen_q) |-> (gap_q == 5'(CYC_CLKS - 1)));

    // R3: each address-latch pulse lasts two clocks
    assert_ale_width_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |=> ale ##1 !ale);

    // R5: code strobe low for three clocks
    assert_psen_width_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(psen_n) |=> !psen_n ##1 !psen_n ##1 psen_n);

    // R6: never two strobes low together
    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!psen_n, !rd_n, !wr_n}));

    // R6: data strobe low for DSTB_LEN clocks
    assert_dstb_width_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_n && wr_n) |-> (dlow_q == 4'(DSTB_LEN)));

    // R7: port released during a read strobe
    assert_no_drive_in_read_R7: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !p0_oe);

    // R7: write byte held one clock after strobe rises and set up one before
    assert_wr_hold_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> p0_oe);
    assert_wr_setup_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_n) |-> $past(p0_oe));

    // R9: capture pulse follows the read strobe rising
    assert_rdvld_R9: assert property (@(posedge clk) disable iff (rst)
        rdata_vld == ($rose(rd_n) || $rose(psen_n)));

endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_take (req_take),
    .ale      (ale),
    .psen_n   (psen_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .p0_oe    (p0_oe),
    .rdata_vld(rdata_vld)
);

// File: tb/tb_bus_cycle_seq.sv
module tb_bus_cycle_seq;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] req_addr = 16'h0100;
    logic [7:0]  req_wdata = 8'h00;
    logic        req_take;
    logic        cfg_we = 1'b0;
    logic        cfg_ale_off = 1'b0;
    logic [7:0]  p0_in = 8'h11;
    logic        ale, psen_n, rd_n, wr_n, p0_oe, rdata_vld;
    logic [7:0]  p0_out, p2_out, rdata;

    bus_cycle_seq dut (
        .clk(clk), .rst(rst), .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_take(req_take), .cfg_we(cfg_we),
        .cfg_ale_off(cfg_ale_off), .p0_in(p0_in), .ale(ale), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe),
        .p2_out(p2_out), .rdata(rdata), .rdata_vld(rdata_vld)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    bit started = 0;

    // behavioural reference state
    int m_ph = 11, m_op = 0, m_ad = 0, m_wd = 0, m_rd = 0;
    bit m_quiet = 0, m_off = 0, m_rv = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // reference model update
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            started = 1;
            m_ph = 11; m_op = 0; m_ad = 0; m_wd = 0; m_rd = 0;
            m_quiet = 0; m_off = 0; m_rv = 0;
        end else begin
            m_rv = 0;
            if ((m_ph == 5 && m_op == 1) || (m_ph == 10 && m_op == 2)) begin
                m_rd = int'(p0_in);
                m_rv = 1;
            end
            if (m_ph == 11) begin
                m_op = int'(req_op); m_ad = int'(req_addr); m_wd = int'(req_wdata);
                m_quiet = m_off && (req_op == 2'd0);
                m_ph = 0;
            end else begin
                m_ph++;
            end
            if (cfg_we) m_off = cfg_ale_off;
        end
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, WATCHDOG);
            finish_run();
        end
    end

    // port input changes every clock
    always @(negedge clk) p0_in <= p0_in + 8'h3B;

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !rst) begin
            bit e_ale, e_oe;
            e_ale = !m_quiet && ((m_ph < 2) || (m_op < 2 && m_ph >= 6 && m_ph < 8));
            e_oe  = (m_op != 0 && m_ph < 2) || (m_op == 3 && m_ph >= 4);
            chk(m_op >= 2 ? "R4" : (m_quiet ? "R10/R11" : "R3"), "ale", int'(ale), int'(e_ale));
            chk("R5", "psen_n", int'(psen_n), int'(!(m_op == 1 && m_ph >= 3 && m_ph <= 5)));
            chk("R6", "rd_n", int'(rd_n), int'(!(m_op == 2 && m_ph >= 5 && m_ph <= 10)));
            chk("R6", "wr_n", int'(wr_n), int'(!(m_op == 3 && m_ph >= 5 && m_ph <= 10)));
            chk("R7", "p0_oe", int'(p0_oe), int'(e_oe));
            if (e_oe)
                chk("R7", "p0_out", int'(p0_out), (m_ph < 2) ? (m_ad & 8'hFF) : m_wd);
            chk("R8", "p2_out", int'(p2_out), (m_op != 0) ? ((m_ad >> 8) & 8'hFF) : 0);
            chk("R2", "req_take", int'(req_take), int'(m_ph == 11));
            chk("R9", "rdata", int'(rdata), m_rd);
            chk("R9", "rdata_vld", int'(rdata_vld), int'(m_rv));
        end
    end

    task automatic run_cycle(input int op, input int ad, input int wd,
                             input bit do_cfg, input bit cfg_val);
        while (m_ph != 11) @(negedge clk);
        req_op    = 2'(op);
        req_addr  = 16'(ad);
        req_wdata = 8'(wd);
        if (do_cfg) begin
            do @(negedge clk); while (m_ph != 4);
            cfg_we = 1'b1; cfg_ale_off = cfg_val;   // mid-cycle write, R11
            @(negedge clk);
            cfg_we = 1'b0;
        end else begin
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R1: reset state while reset is held
        chk("R1", "ale", int'(ale), 0);
        chk("R1", "psen_n", int'(psen_n), 1);
        chk("R1", "rd_n", int'(rd_n), 1);
        chk("R1", "wr_n", int'(wr_n), 1);
        chk("R1", "p0_oe", int'(p0_oe), 0);
        chk("R1", "req_take", int'(req_take), 1);
        chk("R1", "rdata_vld", int'(rdata_vld), 0);
        chk("R1", "rdata", int'(rdata), 0);
        rst = 1'b0;
        // first cycle internal fetch at 0100, suppression bit clear
        @(negedge clk);
        run_cycle(0, 16'h0102, 0, 0, 0);
        run_cycle(1, 16'h1234, 0, 0, 0);
        run_cycle(2, 16'hA55A, 0, 0, 0);
        run_cycle(2, 16'h5AA5, 0, 0, 0);     // back-to-back reads, R4
        run_cycle(3, 16'h00FF, 8'h3C, 0, 0);
        run_cycle(3, 16'hFF00, 8'hC3, 0, 0); // back-to-back writes
        run_cycle(0, 16'h0200, 0, 1, 1);     // set bit mid-cycle: this cycle still pulses
        run_cycle(0, 16'h0202, 0, 0, 0);     // quiet, R10
        run_cycle(0, 16'h0204, 0, 0, 0);
        run_cycle(1, 16'hBEEF, 0, 0, 0);     // strobe returns, R11
        run_cycle(0, 16'h0206, 0, 0, 0);     // quiet again
        run_cycle(2, 16'h8001, 0, 0, 0);
        run_cycle(3, 16'h7FFE, 8'h96, 0, 0);
        run_cycle(0, 16'h0208, 0, 1, 0);     // clear bit mid-cycle: still quiet
        run_cycle(0, 16'h020A, 0, 0, 0);     // pulses again
        run_cycle(1, 16'h4321, 0, 0, 0);
        run_cycle(0, 16'h020C, 0, 0, 0);
        repeat (14) @(negedge clk);
        finish_run();
    end

endmodule